// File: doc/BRIEF.md
# Split Gain Table Index Updater

This block keeps the three index pointers of a receive gain table that is divided into stages: a front-end stage pointer, a filter-stage pointer and a digital gain pointer. The digital pointer is optional at run time. An overload detector upstream issues one command per event, with a valid strobe. The command names the kind of event: a large front-end overload, a large ADC overload, a small ADC overload or digital saturation. The block then chooses the one pointer to lower and the step to lower it by, and clamps the result at zero.

The choice of pointer depends on the event and on the current front-end pointer. A large front-end overload lowers the front-end pointer while that pointer is above zero. Once it is at zero, the same event lowers the filter pointer. An ADC overload of either size lowers the front-end pointer only while that pointer is in the upper part of its table, which means above a programmable limit. Otherwise it lowers the filter pointer. Digital saturation lowers the digital pointer when digital gain is enabled.

Step sizes, the front-end limit, the start values and the maximum indices are all inputs. The decoding of gain words and the detection of overloads are done elsewhere.

Top module: `gain_index_updater`

## Requirements
- R1: While reset is asserted, and after it is released until the first command, each index output shows its start input (`*_init_i`). `done_o` is low.
- R2: Command code 2'b00 (large front-end overload) with `front_idx_o` > 0 lowers the front-end index by `front_step_i` and leaves the other indices unchanged.
- R3: Command code 2'b00 with `front_idx_o` = 0 lowers the filter index by `filt_step_i`. The front-end index stays at 0.
- R4: Command codes 2'b01 (large ADC) and 2'b10 (small ADC) with `front_idx_o` > `front_limit_i` lower the front-end index by `front_step_i`.
- R5: Command codes 2'b01 and 2'b10 with `front_idx_o` <= `front_limit_i` lower the filter index by `filt_step_i` and leave the front-end index unchanged.
- R6: Command code 2'b11 (digital saturation) with `dig_en_i` high lowers the digital index by `dig_step_i`.
- R7: While `dig_en_i` is low, `dig_idx_o` reads 0 and command code 2'b11 leaves all three indices unchanged.
- R8: A decrement whose step is equal to or larger than the current index yields 0. It never wraps.
- R9: An accepted command changes the indices at the first rising edge after `cmd_valid_i` is sampled high. `done_o` is high for exactly that cycle. Without a command the indices hold.
- R10: A start value above its maximum input (`*_max_i`) is clamped to that maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Overload code: 00 large front-end, 01 large ADC, 10 small ADC, 11 digital saturation |
| dig_en_i | input | 1 | Digital gain pointer enable |
| front_limit_i | input | IDX_W | Boundary between the upper and lower front-end table |
| front_step_i | input | STEP_W | Decrement step for the front-end table |
| filt_step_i | input | STEP_W | Decrement step for the filter table |
| dig_step_i | input | STEP_W | Decrement step for the digital table |
| front_init_i | input | IDX_W | Front-end start index |
| filt_init_i | input | IDX_W | Filter start index |
| dig_init_i | input | IDX_W | Digital start index |
| front_max_i | input | IDX_W | Front-end maximum index |
| filt_max_i | input | IDX_W | Filter maximum index |
| dig_max_i | input | IDX_W | Digital maximum index |
| front_idx_o | output | IDX_W | Front-end index |
| filt_idx_o | output | IDX_W | Filter index |
| dig_idx_o | output | IDX_W | Digital index |
| done_o | output | 1 | Update strobe, one cycle |

## Verification
The hardest situation to reach is a front-end index that sits exactly at the limit or exactly at zero, because only a run of earlier commands can walk it there. The bench starts the front-end index a few steps above the limit and sends ADC commands until it crosses into the lower band. It then raises the front-end step so that a single large front-end overload drives the index to zero. From that point further front-end overloads must redirect to the filter table. Saturation at zero is reached the same way, with a step larger than the remaining index, on both the filter and the digital pointers.

// File: rtl/gain_upd_pkg.sv
package gain_upd_pkg;
  typedef enum logic [1:0] {
    OVL_FRONT_LG = 2'b00,
    OVL_ADC_LG   = 2'b01,
    OVL_ADC_SM   = 2'b10,
    OVL_DIG_SAT  = 2'b11
  } ovl_e;

  localparam int unsigned N_PTR   = 3;
  localparam int unsigned P_FRONT = 0;
  localparam int unsigned P_FILT  = 1;
  localparam int unsigned P_DIG   = 2;
endpackage

// File: rtl/gain_upd_route.sv
module gain_upd_route
  import gain_upd_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned STEP_W = 5
) (
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic              dig_en_i,
  input  logic [IDX_W-1:0]  front_idx_i,
  input  logic [IDX_W-1:0]  front_limit_i,
  input  logic [STEP_W-1:0] front_step_i,
  input  logic [STEP_W-1:0] filt_step_i,
  input  logic [STEP_W-1:0] dig_step_i,
  output logic [N_PTR-1:0]  hit_o,
  output logic [STEP_W-1:0] step_o
);
  logic front_upper, front_nonzero;

  assign front_upper   = front_idx_i > front_limit_i;
  assign front_nonzero = |front_idx_i;

  always_comb begin
    hit_o = '0;
    if (cmd_valid_i) begin
      unique case (ovl_e'(cmd_i))
        OVL_FRONT_LG: begin
          if (front_nonzero) hit_o[P_FRONT] = 1'b1;
          else               hit_o[P_FILT]  = 1'b1;
        end
        OVL_ADC_LG, OVL_ADC_SM: begin
          if (front_upper) hit_o[P_FRONT] = 1'b1;
          else             hit_o[P_FILT]  = 1'b1;
        end
        OVL_DIG_SAT: hit_o[P_DIG] = dig_en_i;
        default: hit_o = '0;
      endcase
    end
  end

  // step follows the table being hit, not the event
  always_comb begin
    step_o = '0;
    if (hit_o[P_FRONT])     step_o = front_step_i;
    else if (hit_o[P_FILT]) step_o = filt_step_i;
    else if (hit_o[P_DIG])  step_o = dig_step_i;
  end

  always_comb begin
    assert_dig_gate_R7: assert (!(hit_o[P_DIG] && !dig_en_i))
      else $error("digital pointer hit while disabled");
    assert_single_hit_R2: assert ($onehot0(hit_o))
      else $error("more than one pointer selected");
  end
endmodule

// File: rtl/gain_upd_ptr.sv
module gain_upd_ptr #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned STEP_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seeded_i,
  input  logic [IDX_W-1:0]  init_i,
  input  logic [IDX_W-1:0]  max_i,
  input  logic              hit_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              zero_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] q, seed_val, cur, nxt, step_w;

  assign step_w   = IDX_W'(step_i);
  assign seed_val = (init_i > max_i) ? max_i : init_i;

  always_comb begin
    if (zero_i)        cur = '0;
    else if (seeded_i) cur = q;
    else               cur = seed_val;
  end

  always_comb begin
    nxt = cur;
    if (hit_i) nxt = (cur > step_w) ? (cur - step_w) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign idx_o = cur;

  assert_floor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && (step_w >= cur) |=> q == '0);

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> q <= $past(cur));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i && !zero_i |=> q == $past(cur));
endmodule

// File: rtl/gain_index_updater.sv
module gain_index_updater
  import gain_upd_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned STEP_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic              dig_en_i,
  input  logic [IDX_W-1:0]  front_limit_i,
  input  logic [STEP_W-1:0] front_step_i,
  input  logic [STEP_W-1:0] filt_step_i,
  input  logic [STEP_W-1:0] dig_step_i,
  input  logic [IDX_W-1:0]  front_init_i,
  input  logic [IDX_W-1:0]  filt_init_i,
  input  logic [IDX_W-1:0]  dig_init_i,
  input  logic [IDX_W-1:0]  front_max_i,
  input  logic [IDX_W-1:0]  filt_max_i,
  input  logic [IDX_W-1:0]  dig_max_i,
  output logic [IDX_W-1:0]  front_idx_o,
  output logic [IDX_W-1:0]  filt_idx_o,
  output logic [IDX_W-1:0]  dig_idx_o,
  output logic              done_o
);
  logic                  seeded_q, done_q;
  logic [N_PTR-1:0]      hit;
  logic [STEP_W-1:0]     step;
  logic [IDX_W-1:0]      init_a [N_PTR];
  logic [IDX_W-1:0]      max_a  [N_PTR];
  logic [IDX_W-1:0]      idx_a  [N_PTR];
  logic [N_PTR-1:0]      zero_a;

  assign init_a[P_FRONT] = front_init_i;
  assign init_a[P_FILT]  = filt_init_i;
  assign init_a[P_DIG]   = dig_init_i;
  assign max_a[P_FRONT]  = front_max_i;
  assign max_a[P_FILT]   = filt_max_i;
  assign max_a[P_DIG]    = dig_max_i;
  assign zero_a          = {!dig_en_i, 1'b0, 1'b0};

  // start values stay visible until the first active edge loads them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      seeded_q <= 1'b1;
      done_q   <= cmd_valid_i;
    end
  end

  gain_upd_route #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_route (
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (cmd_i),
    .dig_en_i     (dig_en_i),
    .front_idx_i  (idx_a[P_FRONT]),
    .front_limit_i(front_limit_i),
    .front_step_i (front_step_i),
    .filt_step_i  (filt_step_i),
    .dig_step_i   (dig_step_i),
    .hit_o        (hit),
    .step_o       (step)
  );

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    gain_upd_ptr #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_ptr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .seeded_i(seeded_q),
      .init_i  (init_a[g]),
      .max_i   (max_a[g]),
      .hit_i   (hit[g]),
      .step_i  (step),
      .zero_i  (zero_a[g]),
      .idx_o   (idx_a[g])
    );
  end

  assign front_idx_o = idx_a[P_FRONT];
  assign filt_idx_o  = idx_a[P_FILT];
  assign dig_idx_o   = idx_a[P_DIG];
  assign done_o      = done_q;

  assert_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);

  assert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);

  assert_front_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (ovl_e'(cmd_i) == OVL_FRONT_LG) && (front_idx_o == '0)
    |=> front_idx_o == '0);

  assert_lower_band_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && ((ovl_e'(cmd_i) == OVL_ADC_LG) || (ovl_e'(cmd_i) == OVL_ADC_SM))
    && (front_idx_o <= front_limit_i)
    |=> front_idx_o == $past(front_idx_o));

  always_comb begin
    assert_dig_off_R7: assert (dig_en_i || dig_idx_o == '0)
      else $error("digital index nonzero while disabled");
  end
endmodule

// File: tb/gain_index_updater_test.sv
module gain_index_updater_test;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned STEP_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic dig_en = 1'b1;
  logic [IDX_W-1:0] lim = 7'd10;
  logic [STEP_W-1:0] fstep = 5'd3, lstep = 5'd4, dstep = 5'd2;
  logic [IDX_W-1:0] fin = 7'd20, lin = 7'd50, din = 7'd5;
  logic [IDX_W-1:0] fmax = 7'd31, lmax = 7'd24, dmax = 7'd31;
  logic [IDX_W-1:0] front_idx, filt_idx, dig_idx;
  logic done;

  int n_cmp = 0, n_bad = 0;
  int m_front, m_filt, m_dig;
  bit finished = 0;

  always #10 clk = ~clk;

  gain_index_updater #(.IDX_W(IDX_W), .STEP_W(STEP_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .dig_en_i(dig_en), .front_limit_i(lim), .front_step_i(fstep),
    .filt_step_i(lstep), .dig_step_i(dstep), .front_init_i(fin),
    .filt_init_i(lin), .dig_init_i(din), .front_max_i(fmax),
    .filt_max_i(lmax), .dig_max_i(dmax), .front_idx_o(front_idx),
    .filt_idx_o(filt_idx), .dig_idx_o(dig_idx), .done_o(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat_sub(input int a, input int s);
    return (a > s) ? a - s : 0;
  endfunction

  task automatic check_all(input string tag);
    check({tag, " front"}, int'(front_idx), m_front);
    check({tag, " filt"},  int'(filt_idx),  m_filt);
    check({tag, " dig"},   int'(dig_idx),   m_dig);
  endtask

  // model from the requirements: R2..R7
  task automatic model_step(input logic [1:0] c);
    case (c)
      2'b00: if (m_front > 0) m_front = sat_sub(m_front, int'(fstep));
             else             m_filt  = sat_sub(m_filt, int'(lstep));
      2'b01, 2'b10: if (m_front > int'(lim)) m_front = sat_sub(m_front, int'(fstep));
                    else                     m_filt  = sat_sub(m_filt, int'(lstep));
      default: if (dig_en) m_dig = sat_sub(m_dig, int'(dstep));
    endcase
  endtask

  task automatic issue(input logic [1:0] c, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd = c;
    model_step(c);
    @(negedge clk);
    cmd_valid = 1'b0;
    check_all(tag);
    check({tag, " R9 done high"}, int'(done), 1);
    @(negedge clk);
    check({tag, " R9 done low"}, int'(done), 0);
    check_all({tag, " R9 hold"});
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_front = (fin > fmax) ? int'(fmax) : int'(fin);
    m_filt  = (lin > lmax) ? int'(lmax) : int'(lin);
    m_dig   = !dig_en ? 0 : ((din > dmax) ? int'(dmax) : int'(din));
    check_all({tag, " in reset"});
    check({tag, " done"}, int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all({tag, " after release"});
  endtask

  task automatic t_reset_clamp;
    do_reset("R1 R10 reset");
  endtask

  task automatic t_front_upper;
    issue(2'b00, "R2 front large");
    issue(2'b01, "R4 adc large upper");
    issue(2'b10, "R4 adc small upper");
    issue(2'b10, "R4 adc small crossing");
  endtask

  task automatic t_front_lower;
    issue(2'b10, "R5 adc small lower");
    lim = 7'd8;
    issue(2'b01, "R5 adc large at limit");
  endtask

  task automatic t_front_zero;
    fstep = 5'd15;
    issue(2'b00, "R8 front to zero");
    issue(2'b00, "R3 front at zero");
  endtask

  task automatic t_digital;
    issue(2'b11, "R6 dig sat");
    issue(2'b11, "R6 dig sat second");
    issue(2'b11, "R8 dig floor");
    issue(2'b11, "R8 dig stays zero");
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check_all("R9 idle");
    check("R9 idle done", int'(done), 0);
  endtask

  task automatic t_filt_floor;
    lstep = 5'd31;
    issue(2'b10, "R8 filt floor");
  endtask

  task automatic t_dig_off;
    dig_en = 1'b0;
    do_reset("R7 reset disabled");
    issue(2'b11, "R7 dig sat ignored");
  endtask

  initial begin
    t_reset_clamp();
    t_front_upper();
    t_front_lower();
    t_front_zero();
    t_digital();
    t_idle();
    t_filt_floor();
    t_dig_off();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule